// File: doc/BRIEF.md
# Transfer Completion Record Queue

This block buffers completion records produced by a transfer engine and hands them to software through a small memory-mapped read port. Each record holds a 32-bit count of the bytes that were actually moved, an 8-bit error code and a flag that marks a transfer that ended early. The engine side pushes one record per completed transfer. The queue depth is a parameter.

Software sees the oldest record as two 32-bit words. Word 0 (byte offset 0x0) is the byte count. Word 1 (byte offset 0x4) is the status word. A read is consumed only when it enables the top byte lane of the status word, which is byte address 0x7. Software can therefore read the count and any lower status lanes, in any order, and then retire the record with a final access that covers byte 0x7.

The empty flag, the occupancy count and a sticky overflow flag are outputs, so that neighbouring logic can raise status or interrupts.

Top module: `resp_queue_port`

## Requirements
- R1: A read with `rd_word`=0 returns the oldest record's 32-bit byte count on `rd_data`.
- R2: A read with `rd_word`=1 returns the error code in bits 7:0 and the early-termination flag in bit 8. Bits 31:9 read as zero.
- R3: A read removes the oldest record only when `rd_word`=1 and `rd_byteen[3]`=1. Every other read leaves the occupancy unchanged.
- R4: Byte lanes whose `rd_byteen` bit is 0 read as zero. Bit n of `rd_byteen` covers `rd_data[8n+7:8n]`.
- R5: Read data appears one cycle after the read is accepted, with `rd_valid` high for exactly that one cycle. `rd_valid` is low in every cycle that does not follow an accepted read.
- R6: A read while the queue is empty returns all zeros and removes nothing.
- R7: A push while the queue holds DEPTH records is discarded and sets `overflow`. `overflow` stays set until reset.
- R8: A push and a consuming read in the same cycle, with the queue neither empty nor full, leave the occupancy unchanged. Records always leave in the order they arrived.
- R9: After reset the queue is empty (`empty`=1, `count`=0), `overflow`=0 and `rd_valid`=0. `count` never exceeds DEPTH, and `empty` is high exactly when `count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Push one completion record this cycle |
| push_bytes | input | 32 | Byte count of the record being pushed |
| push_err | input | 8 | Error code of the record being pushed |
| push_early | input | 1 | Early-termination flag of the record being pushed |
| rd_en | input | 1 | Read request, accepted in the same cycle |
| rd_word | input | 1 | Word select: 0 is the byte count, 1 is the status word |
| rd_byteen | input | 4 | Byte-lane enables of the read |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after the accepted read |
| empty | output | 1 | Queue holds no records |
| count | output | $clog2(DEPTH+1) | Number of records held |
| overflow | output | 1 | Sticky flag: a push was discarded because the queue was full |

## Verification
The assertions assume that every input is driven to a known value while reset is released. They also assume that `rd_en` alone qualifies a read, so `rd_word` and `rd_byteen` are only meaningful in the cycles where it is high. The bench changes inputs only at the falling edge and holds all requests low during reset, so these assumptions hold. Its random phase mixes pushes, partial-lane reads and consuming reads while the queue is empty, part-full and full. This reaches the simultaneous push-and-consume case and overflow without leaving the defined input space.

// File: rtl/resp_pkg.sv
// Package: shared record type and lane helpers for the completion queue.
// Assumes a 32-bit read port split into four byte lanes.
package resp_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned LANES  = WORD_W / 8;

    typedef struct packed {
        logic [WORD_W-1:0] bytes;
        logic [7:0]        err;
        logic              early;
    } resp_rec_t;

    // Expand byte enables into a bit mask over the data word.
    function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < int'(LANES); i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/resp_store.sv
// Module: circular record store with occupancy tracking.
// Keeps a push while not full and a pop while not empty, so both can happen
// in the same cycle. Tracks the occupancy and raises a sticky flag when a push
// is discarded. Assumes DEPTH >= 2. The full test uses the occupancy before
// any pop in the same cycle.
module resp_store
    import resp_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  resp_rec_t        push_rec,
    input  logic             pop,
    output resp_rec_t        head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             overflow
);

    resp_rec_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Write the incoming record into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_rec;
        end
    end

    // Advance the pointers with wrap at DEPTH-1 and update the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Latch a discarded push into the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (push && full) begin
            overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/resp_readout.sv
// Module: slave read decode for the oldest record.
// Selects the count word or the status word, blanks the lanes that are not
// enabled, and registers the result with a one-cycle valid strobe. Requests a
// pop only for a status-word read that enables the top lane while the queue
// holds a record. Assumes reads are never stalled.
module resp_readout
    import resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_word,
    input  logic [LANES-1:0]  rd_byteen,
    input  resp_rec_t         head,
    input  logic              empty,
    output logic              pop,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [WORD_W-1:0] status_word;
    logic [WORD_W-1:0] sel_word;

    // Build the status word: error code low, early flag above it, rest zero.
    always_comb begin
        status_word       = '0;
        status_word[7:0]  = head.err;
        status_word[8]    = head.early;
    end

    // Choose the addressed word, or zero when nothing is queued.
    always_comb begin
        if (empty) begin
            sel_word = '0;
        end else if (rd_word) begin
            sel_word = status_word;
        end else begin
            sel_word = head.bytes;
        end
    end

    assign pop = rd_en && rd_word && rd_byteen[LANES-1] && !empty;

    // Register the masked read data and the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= sel_word & lane_mask(rd_byteen);
            end
        end
    end

endmodule

// File: rtl/resp_queue_port.sv
// Module: completion record queue with a memory-mapped readout port (top).
// Joins the record store to the read decode. A read of the status word that
// enables the top byte lane retires the oldest record. Assumes a single
// clock, a synchronous active-low reset and DEPTH >= 2.
module resp_queue_port
    import resp_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [31:0]      push_bytes,
    input  logic [7:0]       push_err,
    input  logic             push_early,
    input  logic             rd_en,
    input  logic             rd_word,
    input  logic [3:0]       rd_byteen,
    output logic [31:0]      rd_data,
    output logic             rd_valid,
    output logic             empty,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);

    resp_rec_t in_rec;
    resp_rec_t head_rec;
    logic      pop_req;
    logic      is_full;

    // Pack the incoming fields into one record.
    always_comb begin
        in_rec.bytes = push_bytes;
        in_rec.err   = push_err;
        in_rec.early = push_early;
    end

    resp_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_valid),
        .push_rec (in_rec),
        .pop      (pop_req),
        .head     (head_rec),
        .count    (count),
        .empty    (empty),
        .full     (is_full),
        .overflow (overflow)
    );

    resp_readout u_readout (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_word   (rd_word),
        .rd_byteen (rd_byteen),
        .head      (head_rec),
        .empty     (empty),
        .pop       (pop_req),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/resp_queue_checker.sv
// Module: port-level property checker for resp_queue_port, attached by bind.
// Assumes inputs are known whenever reset is released.
module resp_queue_checker #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             rd_en,
    input logic             rd_word,
    input logic [3:0]       rd_byteen,
    input logic [31:0]      rd_data,
    input logic             rd_valid,
    input logic             empty,
    input logic [CNT_W-1:0] count,
    input logic             overflow
);

    logic take;
    assign take = rd_en && rd_word && rd_byteen[3];

    p_status_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_word |=> rd_data[31:9] == '0);

    p_keep_on_plain_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !take && !push_valid |=> $stable(count));

    p_valid_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_no_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && empty |=> rd_data == '0);

    p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_full_push_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && !take && count == CNT_W'(DEPTH) |=> count == CNT_W'(DEPTH) && overflow);

    p_swap_keeps_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && take && !empty && count != CNT_W'(DEPTH) |=> $stable(count));

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

endmodule

bind resp_queue_port resp_queue_checker #(.DEPTH(DEPTH)) i_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .rd_en      (rd_en),
    .rd_word    (rd_word),
    .rd_byteen  (rd_byteen),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .empty      (empty),
    .count      (count),
    .overflow   (overflow)
);

// File: tb/test_resp_queue_port.sv
`timescale 1ns/1ps
// Bench: behavioural queue model compared with the design on every falling edge.
module test_resp_queue_port;

    localparam int DEPTH = 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_valid = 1'b0;
    logic [31:0]      push_bytes = '0;
    logic [7:0]       push_err = '0;
    logic             push_early = 1'b0;
    logic             rd_en = 1'b0;
    logic             rd_word = 1'b0;
    logic [3:0]       rd_byteen = '0;
    logic [31:0]      rd_data;
    logic             rd_valid;
    logic             empty;
    logic [CNT_W-1:0] count;
    logic             overflow;

    resp_queue_port #(.DEPTH(DEPTH)) i_resp_queue_port (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_bytes(push_bytes),
        .push_err(push_err), .push_early(push_early), .rd_en(rd_en), .rd_word(rd_word),
        .rd_byteen(rd_byteen), .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
        .count(count), .overflow(overflow)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic [40:0] q[$];
    logic        m_valid = 0;
    logic [31:0] m_data = 0;
    logic        m_ovf = 0;
    string       dtag = "R1";
    string       ctag = "R9";

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("R5", "rd_valid", 32'(rd_valid), 32'(m_valid));
        if (m_valid) chk(dtag, "rd_data", rd_data, m_data);
        chk(ctag, "count", 32'(count), 32'(q.size()));
        chk("R9", "empty", 32'(empty), 32'(q.size() == 0));
        chk("R7", "overflow", 32'(overflow), 32'(m_ovf));
    endtask

    // One cycle: check the previous result, drive new inputs, advance the model.
    task automatic step(input logic p, input logic [31:0] b, input logic [7:0] e, input logic t,
                        input logic r, input logic w, input logic [3:0] be);
        logic [40:0] hd;
        logic [31:0] word;
        bit          take;
        @(negedge clk);
        compare();
        push_valid = p; push_bytes = b; push_err = e; push_early = t;
        rd_en = r; rd_word = w; rd_byteen = be;
        take = r && w && be[3] && q.size() > 0;
        m_valid = r;
        if (r) begin
            if (q.size() == 0) begin
                word = 0; dtag = "R6";
            end else begin
                hd = q[0];
                word = w ? {23'd0, hd[0], hd[8:1]} : hd[40:9];
                dtag = (be != 4'hf) ? "R4" : (w ? "R2" : "R1");
            end
            for (int i = 0; i < 4; i++) if (!be[i]) word[i*8 +: 8] = 8'h00;
            m_data = word;
        end
        ctag = (p && take) ? "R8" : (r ? "R3" : "R9");
        if (p && q.size() == DEPTH) m_ovf = 1;
        if (take) void'(q.pop_front());
        if (p && !(q.size() + (take ? 1 : 0) > DEPTH - 1 + (take ? 1 : 0) && !take && q.size() == DEPTH)) begin
            if (!(q.size() + (take ? 1 : 0) == DEPTH)) q.push_back({b, e, t});
        end
    endtask

    task automatic push(input logic [31:0] b, input logic [7:0] e, input logic t);
        step(1, b, e, t, 0, 0, 4'h0);
    endtask

    task automatic rd(input logic w, input logic [3:0] be);
        step(0, 0, 0, 0, 1, w, be);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state is checked by the first compare
        step(0, 0, 0, 0, 0, 0, 4'h0);
        // R6: read of empty queue gives zero and removes nothing
        rd(1, 4'hf);
        rd(0, 4'hf);
        // R1/R2: fill a few records and read both words
        push(32'h1234_5678, 8'hA5, 1'b1);
        push(32'h0000_0040, 8'h00, 1'b0);
        push(32'hDEAD_BEEF, 8'h3C, 1'b1);
        rd(0, 4'hf);
        rd(1, 4'h7);          // R3: no top lane, no removal
        rd(1, 4'h3);          // R4: partial lanes
        rd(0, 4'h5);          // R4: partial lanes on count word
        rd(1, 4'h8);          // R3: top lane alone removes
        rd(0, 4'hf);
        rd(1, 4'hf);          // R3: removes
        // R8: push and remove in the same cycle
        step(1, 32'h0BAD_F00D, 8'h11, 1'b0, 1, 1, 4'hf);
        rd(0, 4'hf);
        // R7: fill past DEPTH
        for (int i = 0; i < DEPTH + 2; i++) push(32'(i * 16 + 3), 8'(i), i[0]);
        step(1, 32'hFFFF_FFFF, 8'hFF, 1'b1, 1, 1, 4'hf); // full: push dropped, record removed
        // Drain in order (R8 ordering)
        for (int i = 0; i < DEPTH + 1; i++) begin
            rd(0, 4'hf);
            rd(1, 4'hf);
        end
        // R6: push and consuming read on empty queue
        step(1, 32'h0000_0777, 8'h07, 1'b1, 1, 1, 4'hf);
        rd(1, 4'hf);
        // Random mix
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 3) == 0, $urandom, 8'($urandom), 1'($urandom),
                 ($urandom % 2) == 0, 1'($urandom), 4'($urandom));
        end
        step(0, 0, 0, 0, 0, 0, 4'h0);
        step(0, 0, 0, 0, 0, 0, 4'h0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule